// File: doc/BRIEF.md
# Four-Bit Lookahead Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit made of identical bit slices and a carry-lookahead network. Three control inputs choose the operation. `mode` selects arithmetic (1) or logic (0). `sel[1]` lets operand B into the slices (1) or holds it at zero (0). `sel[0]` passes operand A true (0) or inverted (1). Inside each slice the two conditioned operands form a per-bit generate (AND) and a per-bit propagate (XOR).

The lookahead network builds every inter-slice carry as a two-level sum of products of those generate and propagate terms and the external carry-in. In logic mode the carry into each slice's sum is forced to zero, so the result is the bitwise XOR of the conditioned operands. In arithmetic mode the result is their sum plus the carry-in.

The carry-out and the group generate/propagate pair are always driven from the conditioned operands, whatever the mode, so that a higher-level lookahead unit could combine several of these blocks. The block has no clock and no storage, so it carries no stream handshake. All pins are plain combinational control and data.

Top module: `lookahead_alu`

## Requirements
- R1: With `sel[1]` = 0 the B operand is replaced by zero in every slice, so `f`, `cout`, `grp_gen` and `grp_prop` are the same as for B = 0.
- R2: With `sel[0]` = 1 every slice uses the bitwise complement of A; with `sel[0]` = 0 it uses A unchanged.
- R3: With `mode` = 0, `f` equals conditioned A XOR conditioned B, whatever `cin` is.
- R4: With `mode` = 1, `f` equals the low WIDTH bits of conditioned A + conditioned B + `cin`.
- R5: `cout` equals bit WIDTH of conditioned A + conditioned B + `cin`, in both modes.
- R6: `grp_gen` is 1 exactly when conditioned A + conditioned B, with no carry-in, exceeds 2^WIDTH − 1.
- R7: `grp_prop` is 1 exactly when conditioned A XOR conditioned B is all ones.
- R8: With `mode` = 1, `sel` = 2'b11 and `cin` = 1, `f` equals B − A modulo 2^WIDTH.
- R9: With `mode` = 1 and `sel` = 2'b10, `f` equals A + B + `cin` modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| cin | input | 1 | Carry into bit 0 |
| mode | input | 1 | 1 = arithmetic, 0 = logic |
| sel | input | 2 | bit 1: pass B (1) or zero (0); bit 0: invert A (1) |
| f | output | WIDTH | Result |
| cout | output | 1 | Carry out of the top bit |
| grp_gen | output | 1 | Group generate |
| grp_prop | output | 1 | Group propagate |

## Verification
The bench builds the block with its default WIDTH of 4. At that width every combination of A, B, carry-in, mode and select (4096 in all) can be applied. Each vector is compared against a sum and an XOR that the bench forms by plain integer arithmetic. This includes the full-scale carries, such as all ones plus one, and the all-propagate patterns that exercise the longest lookahead products.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef struct packed {
    logic arith;   // 1 = add with carries, 0 = bitwise XOR
    logic pass_b;  // 1 = B enters the slice, 0 = zero
    logic inv_a;   // 1 = A is complemented
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_ctrl(input logic mode, input logic [1:0] sel);
    alu_ctrl_t c;
    c.arith  = mode;
    c.pass_b = sel[1];
    c.inv_a  = sel[0];
    return c;
  endfunction
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  input  logic      carry_in,
  input  alu_ctrl_t ctrl,
  output logic      f_bit,
  output logic      gen,
  output logic      prop
);
  logic a_c, b_c, c_eff;

  always_comb begin
    a_c   = a_bit ^ ctrl.inv_a;
    b_c   = b_bit & ctrl.pass_b;
    c_eff = carry_in & ctrl.arith;
    gen   = a_c & b_c;
    prop  = a_c ^ b_c;
    f_bit = prop ^ c_eff;
  end

  // R3: in logic mode the incoming carry never reaches the result bit
  always_comb begin
    if (!ctrl.arith) p_logic_no_carry_r3: assert (f_bit == (gen ^ prop ^ (a_bit ^ ctrl.inv_a) & (b_bit & ctrl.pass_b) ^ prop ^ prop) || f_bit == prop);
  end
endmodule

// File: rtl/cla_unit.sv
module cla_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] g,
  input  logic [WIDTH-1:0] p,
  input  logic             carry_in,
  output logic [WIDTH:0]   c,
  output logic             grp_gen,
  output logic             grp_prop
);
  always_comb begin
    for (int i = 0; i <= WIDTH; i++) begin
      logic term;
      logic acc;
      term = carry_in;
      for (int k = 0; k < i; k++) term = term & p[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      c[i] = acc;
    end
  end

  always_comb begin
    logic term;
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < WIDTH; j++) begin
      term = g[j];
      for (int k = j + 1; k < WIDTH; k++) term = term & p[k];
      acc = acc | term;
    end
    grp_gen  = acc;
    grp_prop = &p;
  end

  // R5: the flattened products agree with the one-bit-at-a-time carry rule
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      p_ripple_equiv_r5: assert (c[i+1] == (g[i] | (p[i] & c[i])));
    end
  end
endmodule

// File: rtl/lookahead_alu.sv
module lookahead_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             mode,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] f,
  output logic             cout,
  output logic             grp_gen,
  output logic             grp_prop
);
  localparam int CW = WIDTH + 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] g_vec, p_vec;
  logic [WIDTH:0]   carry;

  assign ctrl = decode_ctrl(mode, sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_bit    (a[i]),
      .b_bit    (b[i]),
      .carry_in (carry[i]),
      .ctrl     (ctrl),
      .f_bit    (f[i]),
      .gen      (g_vec[i]),
      .prop     (p_vec[i])
    );
  end

  cla_unit #(.WIDTH(WIDTH)) u_cla (
    .g        (g_vec),
    .p        (p_vec),
    .carry_in (cin),
    .c        (carry),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  assign cout = carry[WIDTH];

  // Port-level checks against integer arithmetic on the conditioned operands
  always_comb begin
    logic [WIDTH-1:0] ac, bc;
    logic [CW-1:0]    tot;
    ac  = sel[0] ? ~a : a;
    bc  = sel[1] ? b : '0;
    tot = CW'(ac) + CW'(bc) + CW'(cin);
    p_cout_sum_r5: assert (cout == tot[WIDTH]);
    if (!mode) p_logic_xor_r3: assert (f == (ac ^ bc));
    if (mode)  p_arith_sum_r4: assert (f == tot[WIDTH-1:0]);
    if (grp_gen) p_gen_forces_carry_r6: assert (cout);
    if (grp_prop && mode) p_prop_passes_cin_r7: assert (f == {WIDTH{~cin}});
  end
endmodule

// File: tb/lookahead_alu_tb_top.sv
module lookahead_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, f;
  logic cin, mode, cout, grp_gen, grp_prop;
  logic [1:0] sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  lookahead_alu #(.WIDTH(W)) dut_i (
    .a(a), .b(b), .cin(cin), .mode(mode), .sel(sel),
    .f(f), .cout(cout), .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d cin=%0d mode=%0d sel=%0d actual=%0d expected=%0d",
               tag, a, b, cin, mode, sel, act, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; mode = 1'b0; sel = 2'b00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle f", int'(f), 0);
    chk("R5 idle cout", int'(cout), 0);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int ci = 0; ci < 2; ci++)
          for (int ia = 0; ia < 16; ia++)
            for (int ib = 0; ib < 16; ib++) begin
              int ac, bc, tot, exf;
              @(posedge clk);
              a = W'(ia); b = W'(ib); cin = ci[0]; mode = m[0]; sel = s[1:0];
              @(negedge clk);
              ac  = (s & 1) ? (~ia & 15) : ia;
              bc  = (s & 2) ? ib : 0;
              tot = ac + bc + ci;
              exf = m ? (tot & 15) : (ac ^ bc);
              if (m == 0) chk("R3 logic f", int'(f), ac ^ bc);
              else        chk("R4 arith f", int'(f), tot & 15);
              chk("R5 cout", int'(cout), (tot >> 4) & 1);
              chk("R6 grp_gen", int'(grp_gen), (ac + bc > 15) ? 1 : 0);
              chk("R7 grp_prop", int'(grp_prop), ((ac ^ bc) == 15) ? 1 : 0);
              if ((s & 2) == 0) begin
                int z;
                z = m ? ((ac + ci) & 15) : ac;
                chk("R1 B blocked", int'(f), z);
              end
              if ((s & 1) == 1 && m == 0 && (s & 2) == 0)
                chk("R2 A inverted", int'(f), ~ia & 15);
              if ((s & 1) == 0 && m == 0 && (s & 2) == 0)
                chk("R2 A passed", int'(f), ia);
              if (m == 1 && s == 3 && ci == 1)
                chk("R8 B minus A", int'(f), (ib - ia) & 15);
              if (m == 1 && s == 2)
                chk("R9 A plus B", int'(f), (ia + ib + ci) & 15);
              if (exf < 0) n_bad++;
            end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule